// File: doc/BRIEF.md
# Software Stimulus Trace Port

This block turns software writes into trace packets. Any bus master may write to it. The master's identifier is supplied alongside the write. The stimulus port number is taken from a field of the write address. Each write is accepted in the cycle it is presented: there is no ready signal on the write side, so a writer is never held up. When tracing is on, the block builds a packet from four things: the master identifier, the port number, the written data and a free-running timestamp. It pushes that packet into a short output queue. The queue drains over a valid/ready stream toward a trace sink.

When the queue is full, a new packet is discarded rather than stalling anything. A saturating counter records each loss. The next packet that does get through carries a flag, so a decoder knows that a gap precedes it. Tracing is switched on and off in two ways: through a small register interface, or by two cross-trigger pulses, one to start and one to stop.

Top module: `swtrace_port`

## Requirements
- R1: After reset, `pkt_valid` is low, tracing is off, and the register reads at index 0 and index 1 both return 0.
- R2: A write accepted while tracing is on and the queue is not full appears as a packet. The packet layout on `pkt_data` is:
  - bit 79: overflow flag
  - bits 78:72: master identifier
  - bits 71:64: port number, equal to write-address bits 15:8
  - bits 63:32: write data
  - bits 31:0: timestamp
- R3: The timestamp is 0 at the first clock edge after reset is released and rises by one at every edge. A packet carries the timestamp value present at the edge that captured its write.
- R4: Writes presented while tracing is off produce no packet and do not change the lost-packet count.
- R5: Register index 0 holds the enable in bit 0; writing it sets or clears tracing, and reading it returns that bit. Index 1 reads the lost-packet count. Every other index reads 0.
- R6: A `xtrig_start` pulse turns tracing on and a `xtrig_stop` pulse turns it off. When both are high, stop wins. Either pulse overrides a register write made in the same cycle.
- R7: Packets leave in write order. While `pkt_valid` is high and `pkt_ready` is low, `pkt_data` holds steady.
- R8: The queue holds four packets. A write that arrives while four are held is dropped, even if one leaves in that same cycle, and the lost count rises by one.
- R9: The 16-bit lost count saturates at 0xFFFF.
- R10: The first packet accepted after one or more drops has the overflow flag set. Later packets have it clear until another drop occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe, always accepted |
| wr_addr | input | 32 | Write address; bits 15:8 select the port |
| wr_data | input | 32 | Write data |
| wr_master | input | 7 | Identifier of the writing master |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| xtrig_start | input | 1 | Cross-trigger start pulse |
| xtrig_stop | input | 1 | Cross-trigger stop pulse |
| pkt_valid | output | 1 | Packet available |
| pkt_ready | input | 1 | Sink accepts the packet |
| pkt_data | output | 80 | Packet contents |

## Verification
The bench fills the queue with the sink stalled and then writes once more. A design that checked fullness after a same-cycle pop, or that overwrote the oldest entry, would lose the wrong packet or fail to count the loss. It drains the queue and checks that the overflow flag lands on the first packet after the drop only; a sticky or missing flag shows up at once. It keeps dropping for more than 65,535 cycles to catch a lost count that wraps to zero. It also drives start, stop and register writes in the same cycle to expose a wrong priority order.

// File: rtl/swtrace_pkg.sv
`timescale 1ns/1ps
package swtrace_pkg;
  localparam int MASTER_W = 7;
  localparam int PORT_W   = 8;
  localparam int DATA_W   = 32;
  localparam int TS_W     = 32;

  typedef struct packed {
    logic                ovf;
    logic [MASTER_W-1:0] master;
    logic [PORT_W-1:0]   port;
    logic [DATA_W-1:0]   data;
    logic [TS_W-1:0]     ts;
  } trace_pkt_t;

  localparam int PKT_W = $bits(trace_pkt_t);

  function automatic trace_pkt_t make_pkt(input logic ovf,
                                          input logic [MASTER_W-1:0] master,
                                          input logic [PORT_W-1:0] port,
                                          input logic [DATA_W-1:0] data,
                                          input logic [TS_W-1:0] ts);
    trace_pkt_t p;
    p.ovf    = ovf;
    p.master = master;
    p.port   = port;
    p.data   = data;
    p.ts     = ts;
    return p;
  endfunction
endpackage

// File: rtl/swtrace_ctrl.sv
`timescale 1ns/1ps
module swtrace_ctrl #(
  parameter int LOST_W = 16,
  parameter int CFG_AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic              cfg_en_bit,
  input  logic              xtrig_start,
  input  logic              xtrig_stop,
  input  logic              drop_evt,
  output logic              trace_en,
  output logic [LOST_W-1:0] lost_cnt,
  output logic [31:0]       cfg_rdata
);
  localparam logic [CFG_AW-1:0] IDX_CTRL = CFG_AW'(0);
  localparam logic [CFG_AW-1:0] IDX_LOST = CFG_AW'(1);
  localparam logic [LOST_W-1:0] LOST_MAX = '1;

  function automatic logic [LOST_W-1:0] sat_inc(input logic [LOST_W-1:0] v);
    return (v == LOST_MAX) ? v : v + 1'b1;
  endfunction

  logic en_next;
  always_comb begin
    en_next = trace_en;
    if (cfg_wr && cfg_addr == IDX_CTRL) en_next = cfg_en_bit;
    if (xtrig_start) en_next = 1'b1;
    if (xtrig_stop)  en_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trace_en <= 1'b0;
      lost_cnt <= '0;
    end else begin
      trace_en <= en_next;
      if (drop_evt) lost_cnt <= sat_inc(lost_cnt);
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == IDX_CTRL)      cfg_rdata = {31'b0, trace_en};
    else if (cfg_addr == IDX_LOST) cfg_rdata = {{(32-LOST_W){1'b0}}, lost_cnt};
  end
endmodule

// File: rtl/swtrace_fmt.sv
`timescale 1ns/1ps
module swtrace_fmt
  import swtrace_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  input  logic [PORT_W-1:0]   wr_port,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [MASTER_W-1:0] wr_master,
  input  logic                trace_en,
  input  logic                fifo_full,
  output logic                push_ok,
  output logic                drop_evt,
  output logic                ovf_pend,
  output trace_pkt_t          push_pkt
);
  logic [TS_W-1:0] ts_q;
  logic            live_wr;

  assign live_wr  = wr_valid && trace_en;
  assign push_ok  = live_wr && !fifo_full;
  assign drop_evt = live_wr && fifo_full;
  assign push_pkt = make_pkt(ovf_pend, wr_master, wr_port, wr_data, ts_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_q     <= '0;
      ovf_pend <= 1'b0;
    end else begin
      ts_q <= ts_q + 1'b1;
      if (drop_evt)     ovf_pend <= 1'b1;
      else if (push_ok) ovf_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/swtrace_fifo.sv
`timescale 1ns/1ps
module swtrace_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign out_valid = (cnt != '0);
  assign full      = (cnt == CW'(DEPTH));
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/swtrace_port.sv
`timescale 1ns/1ps
module swtrace_port
  import swtrace_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int LOST_W     = 16,
  parameter int ADDR_W     = 32,
  parameter int PORT_LSB   = 8,
  parameter int CFG_AW     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [MASTER_W-1:0] wr_master,
  input  logic                cfg_wr,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic                xtrig_start,
  input  logic                xtrig_stop,
  output logic                pkt_valid,
  input  logic                pkt_ready,
  output logic [PKT_W-1:0]    pkt_data
);
  logic              trace_en;
  logic [LOST_W-1:0] lost_cnt;
  logic              push_ok, drop_evt, ovf_pend, fifo_full;
  logic [PORT_W-1:0] wr_port;
  trace_pkt_t        push_pkt;

  assign wr_port = wr_addr[PORT_LSB +: PORT_W];

  swtrace_ctrl #(.LOST_W(LOST_W), .CFG_AW(CFG_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_en_bit(cfg_wdata[0]), .xtrig_start(xtrig_start), .xtrig_stop(xtrig_stop),
    .drop_evt(drop_evt), .trace_en(trace_en), .lost_cnt(lost_cnt), .cfg_rdata(cfg_rdata)
  );

  swtrace_fmt u_fmt (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_port(wr_port),
    .wr_data(wr_data), .wr_master(wr_master), .trace_en(trace_en),
    .fifo_full(fifo_full), .push_ok(push_ok), .drop_evt(drop_evt),
    .ovf_pend(ovf_pend), .push_pkt(push_pkt)
  );

  swtrace_fifo #(.DEPTH(FIFO_DEPTH), .W(PKT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .push_data(push_pkt),
    .out_ready(pkt_ready), .out_valid(pkt_valid), .out_data(pkt_data),
    .full(fifo_full)
  );
endmodule

// File: rtl/swtrace_chk.sv
`timescale 1ns/1ps
module swtrace_chk #(
  parameter int LOST_W = 16,
  parameter int PKT_W  = 80
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              trace_en,
  input logic              push_ok,
  input logic              drop_evt,
  input logic              ovf_pend,
  input logic [LOST_W-1:0] lost_cnt,
  input logic              pkt_valid,
  input logic              pkt_ready,
  input logic [PKT_W-1:0]  pkt_data,
  input logic              xtrig_start,
  input logic              xtrig_stop
);
  localparam logic [LOST_W-1:0] LMAX = '1;

  assert_idle_discard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !trace_en) |-> (!push_ok && !drop_evt));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data)));

  assert_drop_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> ((lost_cnt == LOST_W'($past(lost_cnt) + 1'b1)) ||
                  ($past(lost_cnt) == LMAX && lost_cnt == LMAX)));

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_cnt == LMAX) |=> (lost_cnt == LMAX));

  assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> ovf_pend);

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> !ovf_pend);

  assert_stop_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xtrig_stop |=> !trace_en);

  assert_start_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xtrig_start && !xtrig_stop) |=> trace_en);
endmodule

bind swtrace_port swtrace_chk #(.LOST_W(LOST_W), .PKT_W(swtrace_pkg::PKT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .trace_en(trace_en),
  .push_ok(push_ok), .drop_evt(drop_evt), .ovf_pend(ovf_pend),
  .lost_cnt(lost_cnt), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
  .pkt_data(pkt_data), .xtrig_start(xtrig_start), .xtrig_stop(xtrig_stop)
);

// File: tb/sim_swtrace_port.sv
`timescale 1ns/1ps
module sim_swtrace_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  wr_master = '0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        xtrig_start = 1'b0;
  logic        xtrig_stop = 1'b0;
  logic        pkt_valid;
  logic        pkt_ready = 1'b0;
  logic [79:0] pkt_data;

  int total = 0;
  int bad = 0;
  logic [31:0] cyc;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 1;
  end

  swtrace_port u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_master(wr_master), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .xtrig_start(xtrig_start), .xtrig_stop(xtrig_stop), .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready), .pkt_data(pkt_data)
  );

  // {master[6:0], addr[31:0], data[31:0]}
  localparam logic [70:0] VEC [6] = '{
    {7'h01, 32'h0000_0000, 32'h0000_0000},
    {7'h7F, 32'h0000_FF00, 32'hFFFF_FFFF},
    {7'h2A, 32'hFFFF_12FF, 32'hDEAD_BEEF},
    {7'h40, 32'h1234_8004, 32'h0000_0001},
    {7'h00, 32'h0000_0100, 32'h8000_0000},
    {7'h55, 32'hA5A5_3C5A, 32'h1357_9BDF}
  };

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    cfg_addr = a;
    #0.5;
    chk(cfg_rdata == exp, tag, {48'b0, cfg_rdata}, {48'b0, exp});
  endtask

  task automatic wr_drive(input logic [6:0] m, input logic [31:0] a, input logic [31:0] d);
    wr_valid = 1'b1; wr_master = m; wr_addr = a; wr_data = d;
  endtask

  initial begin : watchdog
    #(5.0 * 190000);
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [79:0] exp_pkt;
    repeat (3) step();
    // R1: reset state
    chk(pkt_valid == 1'b0, "R1 pkt_valid in reset", {79'b0, pkt_valid}, 80'd0);
    rst_n = 1'b1;
    step();
    chk(pkt_valid == 1'b0, "R1 pkt_valid after reset", {79'b0, pkt_valid}, 80'd0);
    rd_chk(2'd0, 32'd0, "R1 ctrl zero");
    rd_chk(2'd1, 32'd0, "R1 lost zero");

    // R4: writes while tracing is off
    wr_drive(7'h11, 32'h0000_0500, 32'h1111_1111);
    step(); step();
    wr_valid = 1'b0;
    chk(pkt_valid == 1'b0, "R4 no packet when off", {79'b0, pkt_valid}, 80'd0);
    rd_chk(2'd1, 32'd0, "R4 lost untouched");

    // R5: register map
    cfg_write(2'd0, 32'h0000_0001);
    rd_chk(2'd0, 32'd1, "R5 enable readback");
    rd_chk(2'd2, 32'd0, "R5 unmapped index");
    rd_chk(2'd3, 32'd0, "R5 unmapped index 3");

    // R2/R3: vector table, sink always ready
    pkt_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      wr_drive(VEC[i][70:64], VEC[i][63:32], VEC[i][31:0]);
      exp_pkt = {1'b0, VEC[i][70:64], VEC[i][47:40], VEC[i][31:0], cyc};
      step();
      chk(pkt_valid == 1'b1, "R2 packet valid", {79'b0, pkt_valid}, 80'd1);
      chk(pkt_data == exp_pkt, "R2 R3 packet fields", pkt_data, exp_pkt);
    end
    wr_valid = 1'b0;
    step();
    chk(pkt_valid == 1'b0, "R2 drained", {79'b0, pkt_valid}, 80'd0);

    // R6: cross triggers and priority
    cfg_write(2'd0, 32'd0);
    xtrig_start = 1'b1; step(); xtrig_start = 1'b0;
    rd_chk(2'd0, 32'd1, "R6 start enables");
    xtrig_stop = 1'b1; step(); xtrig_stop = 1'b0;
    rd_chk(2'd0, 32'd0, "R6 stop disables");
    xtrig_start = 1'b1; xtrig_stop = 1'b1; step();
    xtrig_start = 1'b0; xtrig_stop = 1'b0;
    rd_chk(2'd0, 32'd0, "R6 stop beats start");
    xtrig_stop = 1'b1; cfg_write(2'd0, 32'd1); xtrig_stop = 1'b0;
    rd_chk(2'd0, 32'd0, "R6 stop beats reg write");
    xtrig_start = 1'b1; cfg_write(2'd0, 32'd0); xtrig_start = 1'b0;
    rd_chk(2'd0, 32'd1, "R6 start beats reg write");

    // R7/R8: fill with sink stalled, then one more
    pkt_ready = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      wr_drive(7'(k), 32'h0000_0200, 32'(k));
      step();
    end
    wr_valid = 1'b0;
    rd_chk(2'd1, 32'd1, "R8 fifth write dropped");
    chk(pkt_data[78:72] == 7'd1, "R7 head is oldest", {73'b0, pkt_data[78:72]}, 80'd1);
    step(); step();
    chk(pkt_data[78:72] == 7'd1, "R7 head held while stalled", {73'b0, pkt_data[78:72]}, 80'd1);
    // drop while a pop happens in the same cycle
    pkt_ready = 1'b1;
    wr_drive(7'h33, 32'h0, 32'h0);
    step();
    wr_valid = 1'b0;
    rd_chk(2'd1, 32'd2, "R8 full counts before pop");
    for (int k = 2; k <= 4; k++) begin
      chk(pkt_valid && pkt_data[78:72] == 7'(k) && !pkt_data[79], "R7 order and no flag",
          pkt_data, {1'b0, 7'(k), 72'b0});
      step();
    end
    chk(pkt_valid == 1'b0, "R8 queue empty", {79'b0, pkt_valid}, 80'd0);

    // R10: flag on first accepted packet only
    wr_drive(7'h06, 32'h0, 32'h6); step();
    chk(pkt_valid && pkt_data[79] && pkt_data[78:72] == 7'h06, "R10 flag set",
        pkt_data, {1'b1, 7'h06, 72'b0});
    wr_drive(7'h07, 32'h0, 32'h7); step();
    wr_valid = 1'b0;
    chk(pkt_valid && !pkt_data[79] && pkt_data[78:72] == 7'h07, "R10 flag cleared",
        pkt_data, {1'b0, 7'h07, 72'b0});
    step();

    // R9: saturation of the lost count
    pkt_ready = 1'b0;
    wr_drive(7'h09, 32'h0, 32'h9);
    repeat (4) step();
    repeat (70000) step();
    wr_valid = 1'b0;
    rd_chk(2'd1, 32'h0000_FFFF, "R9 lost saturates");
    wr_drive(7'h09, 32'h0, 32'h9); step(); wr_valid = 1'b0;
    rd_chk(2'd1, 32'h0000_FFFF, "R9 no wrap");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule